// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Unit

This unit watches a group of general-purpose input pins and records every level change on them as an interrupt event. Each pin has a polarity bit that decides which direction of change is its "assert" event and which is its "deassert" event. The two kinds of event go into two separate sticky status words, and each word drives its own interrupt line. A line is raised only by status bits whose pin is enabled.

Software reaches the unit through a plain single-cycle register port. A write to a status word carries a mode flag in bit 0. With the flag low, every status bit written as 1 is cleared. With the flag high, every status bit written as 1 is set. In both modes, bits written as 0 are left unchanged. A pin that must report both directions is given polarity 1, and both status words are serviced for it. Before edge detection, the pins are retimed by a two-stage synchroniser.

Top module: `gpev_irq_unit`

## Requirements
- R1: After reset, every register (enable, polarity and both status words) reads 0, and both interrupt outputs are low.
- R2: With polarity 1, a rising edge on pin k sets bit k+1 of the assert status word (address 2), and a falling edge sets bit k+1 of the deassert status word (address 3).
- R3: With polarity 0, a falling edge on pin k sets assert status bit k+1, and a rising edge sets deassert status bit k+1. Several pins changing in the same cycle are all recorded.
- R4: A write to a status word with wdata bit 0 equal to 0 clears each status bit whose wdata bit is 1. All other bits keep their value.
- R5: A write to a status word with wdata bit 0 equal to 1 sets each status bit whose wdata bit is 1. All other bits keep their value.
- R6: A status word always reads with bit 0 equal to 0, including just after a write in set mode.
- R7: Status bits latch whether or not the pin is enabled. The enable register (address 0) holds pin k at bit k. Each interrupt output is high exactly when some status bit k+1 of its word has enable bit k set. The output stays high until that status bit or that enable bit is cleared.
- R8: When an edge and a clear write reach the same status bit in the same cycle, the bit ends up set.
- R9: An edge on a pin appears in its status word, and in the interrupt output, on the third rising clock edge after the pin changes, and not earlier.
- R10: The enable register (address 0) and the polarity register (address 1) read back the values last written to them. Bit 31 reads 0.
- R11: Read data appears on rdata, with rd_valid high, one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 31 | Asynchronous GPIO input levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 enable, 1 polarity, 2 assert status, 3 deassert status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | High the cycle after a read |
| irq_assert | output | 1 | Interrupt from the assert status word |
| irq_deassert | output | 1 | Interrupt from the deassert status word |

## Verification
The hardest case to reach from the ports is an edge that lands in the very cycle a clear write hits the same status bit. The hardware resolves that collision inside one clock, and nothing reveals it afterwards except the final bit value. The stimulus therefore changes the pin one cycle before it starts a clear write. It counts the three synchroniser and edge register stages, so the edge pulse meets the write edge exactly. The same write also clears a different, pre-set bit, which shows the clear itself took effect.

// File: rtl/gpev_pkg.sv
`timescale 1ns/1ps
package gpev_pkg;
  typedef enum logic [1:0] {
    SEL_ENA = 2'd0,
    SEL_POL = 2'd1,
    SEL_AST = 2'd2,
    SEL_DST = 2'd3
  } gpev_sel_e;

  // Bit of a status write that picks set (1) or clear (0).
  localparam int GPEV_MODE_BIT = 0;
endpackage

// File: rtl/gpev_sync.sv
`timescale 1ns/1ps
module gpev_sync #(
  parameter int W      = 31,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpev_edge.sv
`timescale 1ns/1ps
module gpev_edge #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  output logic [W-1:0] a_hit,
  output logic [W-1:0] d_hit
);
  logic [W-1:0] prev;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise  = lvl & ~prev;
  assign fall  = ~lvl & prev;
  // Polarity 1: rise asserts, fall deasserts; polarity 0 swaps them.
  assign a_hit = (rise & pol) | (fall & ~pol);
  assign d_hit = (fall & pol) | (rise & ~pol);
endmodule

// File: rtl/gpev_status.sv
`timescale 1ns/1ps
module gpev_status
  import gpev_pkg::*;
#(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W:0]   wdata,
  input  logic [W-1:0] hit,
  output logic [W:0]   word
);
  logic [W-1:0] st;
  logic [W-1:0] st_nx;
  logic [W-1:0] sel_bits;
  logic         set_mode;

  assign sel_bits = wdata[W:1];
  assign set_mode = wdata[GPEV_MODE_BIT];

  always_comb begin
    st_nx = st;
    if (wr) begin
      if (set_mode) st_nx = st_nx | sel_bits;
      else          st_nx = st_nx & ~sel_bits;
    end
    // A new edge always wins over a clear in the same cycle.
    st_nx = st_nx | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= st_nx;
  end

  assign word = {st, 1'b0};
endmodule

// File: rtl/gpev_irq_unit.sv
`timescale 1ns/1ps
module gpev_irq_unit
  import gpev_pkg::*;
#(
  parameter int NPIN = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [NPIN:0]     wdata,
  output logic [NPIN:0]     rdata,
  output logic              rd_valid,
  output logic              irq_assert,
  output logic              irq_deassert
);
  localparam int DW = NPIN + 1;
  localparam int NWORD = 2;

  logic [NPIN-1:0] ie_q;
  logic [NPIN-1:0] pol_q;
  logic [NPIN-1:0] lvl_s;
  logic [NPIN-1:0] a_hit;
  logic [NPIN-1:0] d_hit;
  logic [DW-1:0]   ast_word;
  logic [DW-1:0]   dst_word;
  logic [NPIN-1:0] hit_v  [NWORD];
  logic [DW-1:0]   word_v [NWORD];
  logic [NWORD-1:0] irq_v;
  gpev_sel_e       sel;

  assign sel = gpev_sel_e'(addr);

  gpev_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_s)
  );

  gpev_edge #(.W(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .pol(pol_q),
    .a_hit(a_hit), .d_hit(d_hit)
  );

  assign hit_v[0] = a_hit;
  assign hit_v[1] = d_hit;

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    localparam gpev_sel_e MY_SEL = (g == 0) ? SEL_AST : SEL_DST;
    logic wr_me;
    assign wr_me = wr_en && (sel == MY_SEL);
    gpev_status #(.W(NPIN)) u_st (
      .clk(clk), .rst_n(rst_n), .wr(wr_me), .wdata(wdata),
      .hit(hit_v[g]), .word(word_v[g])
    );
    assign irq_v[g] = |(word_v[g][DW-1:1] & ie_q);
  end

  assign ast_word     = word_v[0];
  assign dst_word     = word_v[1];
  assign irq_assert   = irq_v[0];
  assign irq_deassert = irq_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= '0;
      pol_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_ENA) ie_q  <= wdata[NPIN-1:0];
      if (sel == SEL_POL) pol_q <= wdata[NPIN-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (sel)
          SEL_ENA: rdata <= {1'b0, ie_q};
          SEL_POL: rdata <= {1'b0, pol_q};
          SEL_AST: rdata <= ast_word;
          default: rdata <= dst_word;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpev_chk.sv
`timescale 1ns/1ps
module gpev_chk
  import gpev_pkg::*;
#(
  parameter int NPIN = 31
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [1:0]      addr,
  input logic [NPIN:0]   wdata,
  input logic [NPIN:0]   rdata,
  input logic            irq_assert,
  input logic            irq_deassert,
  input logic [NPIN-1:0] ie_q,
  input logic [NPIN-1:0] a_hit,
  input logic [NPIN-1:0] d_hit,
  input logic [NPIN:0]   ast_word,
  input logic [NPIN:0]   dst_word
);
  logic wr_ast, wr_dst, rd_st;
  assign wr_ast = wr_en && (addr == SEL_AST);
  assign wr_dst = wr_en && (addr == SEL_DST);
  assign rd_st  = rd_en && (addr[1] == 1'b1);

  a_r2_hits_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hit & d_hit) == '0);

  // R8: an edge pulse is captured even when a clear write coincides.
  a_r8_ahit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|a_hit) |=> ((ast_word[NPIN:1] & $past(a_hit)) == $past(a_hit)));

  a_r8_dhit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|d_hit) |=> ((dst_word[NPIN:1] & $past(d_hit)) == $past(d_hit)));

  a_r4_clear_ast: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ast && !wdata[GPEV_MODE_BIT]) |=>
      ((ast_word[NPIN:1] & $past(wdata[NPIN:1]) & ~$past(a_hit)) == '0));

  a_r5_set_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dst && wdata[GPEV_MODE_BIT]) |=>
      ((dst_word[NPIN:1] & $past(wdata[NPIN:1])) == $past(wdata[NPIN:1])));

  a_r6_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |=> !rdata[0]);

  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_assert && !wr_ast && !(wr_en && addr == SEL_ENA)) |=> irq_assert);

  a_r7_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> (!irq_assert && !irq_deassert));

  a_r10_ena_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_ENA) |=> (rdata == {1'b0, $past(ie_q)}));
endmodule

bind gpev_irq_unit gpev_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_assert(irq_assert),
  .irq_deassert(irq_deassert), .ie_q(ie_q), .a_hit(a_hit), .d_hit(d_hit),
  .ast_word(ast_word), .dst_word(dst_word)
);

// File: tb/tb_gpev_irq_unit.sv
`timescale 1ns/1ps
module tb_gpev_irq_unit;
  localparam int NPIN = 31;
  localparam logic [1:0] A_ENA = 2'd0, A_POL = 2'd1, A_AST = 2'd2, A_DST = 2'd3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic [NPIN-1:0] pin_in;
  logic            wr_en, rd_en;
  logic [1:0]      addr;
  logic [NPIN:0]   wdata;
  logic [NPIN:0]   rdata;
  logic            rd_valid, irq_assert, irq_deassert;

  gpev_irq_unit #(.NPIN(NPIN)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .irq_assert(irq_assert), .irq_deassert(irq_deassert)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read values as results come out.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected read", 32'(rdata), 32'hDEAD_BEEF);
      end else begin
        check(tag_q.pop_front(), 32'(rdata), exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; pin_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq_assert", 32'(irq_assert), 0);
    check("R1 irq_deassert", 32'(irq_deassert), 0);
    rd(A_ENA, 0, "R1 enable"); rd(A_POL, 0, "R1 polarity");
    rd(A_AST, 0, "R1 assert status"); rd(A_DST, 0, "R1 deassert status");

    wr(A_ENA, 32'hFFFF_FFFF); rd(A_ENA, 32'h7FFF_FFFF, "R10 enable readback");
    wr(A_POL, 32'h1234_5678); rd(A_POL, 32'h1234_5678, "R10 polarity readback");
    wr(A_ENA, 32'h1); wr(A_POL, 32'h1);

    // R9 latency, R2 polarity 1 rising edge
    @(posedge clk); #1 pin_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 not before third edge", 32'(irq_assert), 0);
    @(negedge clk);
    check("R9 on third edge", 32'(irq_assert), 1);
    check("R2 no deassert on rise", 32'(irq_deassert), 0);
    rd(A_AST, 32'h2, "R2 rise sets assert bit1");
    @(posedge clk); #1 pin_in[0] = 1'b0;
    settle();
    rd(A_DST, 32'h2, "R2 fall sets deassert bit1");
    @(negedge clk);
    check("R7 deassert irq", 32'(irq_deassert), 1);

    wr(A_AST, 32'h3); rd(A_AST, 32'h2, "R6 bit0 reads zero");
    wr(A_AST, 32'h2);
    @(negedge clk);
    check("R4 irq drops after clear", 32'(irq_assert), 0);
    rd(A_AST, 0, "R4 clear assert");
    wr(A_DST, 32'h2); rd(A_DST, 0, "R4 clear deassert");

    wr(A_AST, 32'h8000_0011); rd(A_AST, 32'h8000_0010, "R5 set mode");
    @(negedge clk);
    check("R7 latched but disabled", 32'(irq_assert), 0);
    wr(A_ENA, 32'h4000_0001);
    @(negedge clk);
    check("R7 enabling raises irq", 32'(irq_assert), 1);
    wr(A_AST, 32'hFFFF_FFFE); rd(A_AST, 0, "R4 clear all");

    // R3 polarity 0 on pin7
    @(posedge clk); #1 pin_in[7] = 1'b1;
    settle();
    rd(A_DST, 32'h100, "R3 rise is deassert"); rd(A_AST, 0, "R3 rise no assert");
    @(posedge clk); #1 pin_in[7] = 1'b0;
    settle();
    rd(A_AST, 32'h100, "R3 fall is assert");
    @(negedge clk);
    check("R7 pin7 not enabled", 32'(irq_assert), 0);
    @(posedge clk); #1 pin_in[2:0] = 3'b111;
    settle();
    rd(A_AST, 32'h102, "R3 simultaneous assert");
    rd(A_DST, 32'h10C, "R3 simultaneous deassert");
    wr(A_AST, 32'hFFFF_FFFE); wr(A_DST, 32'hFFFF_FFFE);

    // R8 edge coinciding with clear
    wr(A_DST, 32'h0000_0801);
    @(posedge clk); #1 pin_in[5] = 1'b1;
    @(posedge clk);
    wr(A_DST, 32'h0000_0840);
    rd(A_DST, 32'h40, "R8 edge beats clear");

    repeat (4) @(posedge clk);
    check("R11 all reads returned", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule